// File: doc/BRIEF.md
# Performance Counter Slot Allocator

This block hands out a bank of ten performance-counter slots to monitoring events, one request at a time. Each request brings an event code and a ten-bit mask. Bit i of the mask set means slot i may count that event. The block takes the lowest-numbered allowed slot that is still free. It marks that slot busy and stores the event code in the slot's configuration register. One cycle later it reports whether the request succeeded and which slot it got.

Allocation is greedy and there is no backtracking. Slots 0 and 1 serve the cycle and instruction events, which use masks 0b0000000001 and 0b0000000010. General events compete for slots 2 to 9. For this reason the order of requests matters. A wide-mask event (0b1111111100) takes the lowest free general slot. A run of such events can therefore use up the single slot that a narrow-mask event (0b0010000000, slot 7 only) needed. The same events requested in the opposite order all fit.

Software can free every slot at once with a synchronous clear. Reset has the same effect. A free-slot count and the occupancy vector show the state at all times.

Top module: `pmu_slot_allocator`

## Requirements
- R1: After reset, and in the cycle after a clear, every slot is free. `slot_busy` is 0, `free_count` is 10 and every configuration field is 0.
- R2: `grant_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. Whenever `grant_ok` is 0, `grant_slot` reads 0.
- R3: An accepted request gets the lowest-index slot whose mask bit is set and which is free. Slot i corresponds to mask bit i.
- R4: On acceptance, `slot_busy[s]` becomes 1 and `slot_config[8*s+7:8*s]` takes the request's event code, where s is the granted slot.
- R5: A request with an all-zero mask, or with every allowed slot busy, returns `grant_ok` = 0 and leaves `slot_busy` and `slot_config` unchanged.
- R6: A request with mask 0b0000000001 lands in slot 0 and one with mask 0b0000000010 lands in slot 1, whatever the general slots hold.
- R7: Consider six requests with mask 0b1111111100 followed by one with mask 0b0010000000. The wide requests take slots 2 to 7 and the narrow one is refused. In the opposite order the narrow request takes slot 7 and the wide ones take 2, 3, 4, 5, 6 and 8.
- R8: A second request with mask 0b0010000000 is refused while slot 7 is held.
- R9: A request in the same cycle as `clear` is judged against an empty bank. Afterwards only its granted slot is busy.
- R10: `free_count` always equals 10 minus the number of set bits in `slot_busy`. At most one slot changes from free to busy per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, frees all slots |
| clear | input | 1 | Synchronous release of every slot |
| req_valid | input | 1 | Allocation request strobe |
| req_event_id | input | 8 | Event code to program into the granted slot |
| req_mask | input | 10 | Slots allowed for this event, bit i = slot i |
| grant_valid | output | 1 | Result of the previous cycle's request is present |
| grant_ok | output | 1 | Request accepted |
| grant_slot | output | 4 | Granted slot index, 0 on refusal |
| slot_busy | output | 10 | Occupancy per slot |
| slot_config | output | 80 | Event code per slot, slot i in bits [8i+7:8i] |
| free_count | output | 4 | Number of unoccupied slots |

## Verification
A corrupted occupancy bit shows up in the cycle after the next request that touches it. Either a slot is granted twice, or a refusal arrives while `free_count` still shows room in the mask. A wrong scan order shows at once as a higher slot index than the lowest free allowed one. The wide-then-narrow and narrow-then-wide sequences expose it within seven requests. A configuration field written to the wrong slot, or overwritten on a refusal, is visible on `slot_config` right after the grant.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  localparam int unsigned DEF_NUM_SLOTS = 10;
  localparam int unsigned DEF_EVENT_W   = 8;

  typedef struct packed {
    logic clearAll;  // release every slot
    logic commit;    // claim the picked slot
  } allocStrobe_t;
endpackage

// File: rtl/slot_alloc_datapath.sv
module slot_alloc_datapath
  import slot_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  parameter int unsigned EVENT_W   = DEF_EVENT_W,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  allocStrobe_t                 strobe,
  input  logic                         clearReq,
  input  logic [NUM_SLOTS-1:0]         reqMask,
  input  logic [EVENT_W-1:0]           reqEventId,
  output logic                         found,
  output logic [IDX_W-1:0]             pickIdx,
  output logic [NUM_SLOTS-1:0]         occupied,
  output logic [NUM_SLOTS*EVENT_W-1:0] cfgBus,
  output logic [CNT_W-1:0]             freeCount
);

  logic [NUM_SLOTS-1:0] effOcc;
  logic [NUM_SLOTS-1:0] avail;

  // A clear in the same cycle makes the request see an empty bank
  assign effOcc = clearReq ? '0 : occupied;
  assign avail  = reqMask & ~effOcc;

  // First-fit: lowest set bit of avail wins
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (avail[i]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(i);
      end
    end
  end

  // Occupancy and per-slot configuration
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    logic hitSlot;
    assign hitSlot = strobe.commit && (pickIdx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occupied[s]                     <= 1'b0;
        cfgBus[s*EVENT_W +: EVENT_W]    <= '0;
      end else if (hitSlot) begin
        occupied[s]                     <= 1'b1;
        cfgBus[s*EVENT_W +: EVENT_W]    <= reqEventId;
      end else if (strobe.clearAll) begin
        occupied[s]                     <= 1'b0;
        cfgBus[s*EVENT_W +: EVENT_W]    <= '0;
      end
    end
  end

  // Number of free slots in the current state
  always_comb begin
    freeCount = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      freeCount = freeCount + CNT_W'(!occupied[i]);
    end
  end

endmodule

// File: rtl/slot_alloc_ctrl.sv
module slot_alloc_ctrl
  import slot_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearReq,
  input  logic             reqValid,
  input  logic             found,
  input  logic [IDX_W-1:0] pickIdx,
  output allocStrobe_t     strobe,
  output logic             grantValid,
  output logic             grantOk,
  output logic [IDX_W-1:0] grantSlot
);

  logic acceptNow;
  assign acceptNow       = reqValid && found;
  assign strobe.commit   = acceptNow;
  assign strobe.clearAll = clearReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grantValid <= 1'b0;
      grantOk    <= 1'b0;
      grantSlot  <= '0;
    end else begin
      grantValid <= reqValid;
      grantOk    <= acceptNow;
      grantSlot  <= acceptNow ? pickIdx : '0;
    end
  end

endmodule

// File: rtl/pmu_slot_allocator.sv
module pmu_slot_allocator
  import slot_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  parameter int unsigned EVENT_W   = DEF_EVENT_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clear,
  input  logic                                req_valid,
  input  logic [EVENT_W-1:0]                  req_event_id,
  input  logic [NUM_SLOTS-1:0]                req_mask,
  output logic                                grant_valid,
  output logic                                grant_ok,
  output logic [$clog2(NUM_SLOTS)-1:0]        grant_slot,
  output logic [NUM_SLOTS-1:0]                slot_busy,
  output logic [NUM_SLOTS*EVENT_W-1:0]        slot_config,
  output logic [$clog2(NUM_SLOTS+1)-1:0]      free_count
);

  localparam int unsigned IDX_W = $clog2(NUM_SLOTS);

  allocStrobe_t     strobe;
  logic             found;
  logic [IDX_W-1:0] pickIdx;

  slot_alloc_datapath #(.NUM_SLOTS(NUM_SLOTS), .EVENT_W(EVENT_W)) uDatapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .clearReq   (clear),
    .reqMask    (req_mask),
    .reqEventId (req_event_id),
    .found      (found),
    .pickIdx    (pickIdx),
    .occupied   (slot_busy),
    .cfgBus     (slot_config),
    .freeCount  (free_count)
  );

  slot_alloc_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clearReq   (clear),
    .reqValid   (req_valid),
    .found      (found),
    .pickIdx    (pickIdx),
    .strobe     (strobe),
    .grantValid (grant_valid),
    .grantOk    (grant_ok),
    .grantSlot  (grant_slot)
  );

endmodule

// File: rtl/pmu_slot_allocator_chk.sv
module pmu_slot_allocator_chk #(
  parameter int unsigned NUM_SLOTS = 10,
  parameter int unsigned EVENT_W   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           clear,
  input logic                           req_valid,
  input logic [EVENT_W-1:0]             req_event_id,
  input logic [NUM_SLOTS-1:0]           req_mask,
  input logic                           grant_valid,
  input logic                           grant_ok,
  input logic [$clog2(NUM_SLOTS)-1:0]   grant_slot,
  input logic [NUM_SLOTS-1:0]           slot_busy,
  input logic [NUM_SLOTS*EVENT_W-1:0]   slot_config,
  input logic [$clog2(NUM_SLOTS+1)-1:0] free_count
);

  logic                         prevValid;
  logic                         prevClear;
  logic [NUM_SLOTS-1:0]         prevMask;
  logic [NUM_SLOTS-1:0]         prevBusy;
  logic [EVENT_W-1:0]           prevId;
  logic [NUM_SLOTS*EVENT_W-1:0] prevCfg;
  logic [NUM_SLOTS-1:0]         prevFreeView;
  logic [NUM_SLOTS-1:0]         belowGrant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevValid <= 1'b0;
      prevClear <= 1'b0;
      prevMask  <= '0;
      prevBusy  <= '0;
      prevId    <= '0;
      prevCfg   <= '0;
    end else begin
      prevValid <= req_valid;
      prevClear <= clear;
      prevMask  <= req_mask;
      prevBusy  <= slot_busy;
      prevId    <= req_event_id;
      prevCfg   <= slot_config;
    end
  end

  assign prevFreeView = prevMask & ~(prevClear ? '0 : prevBusy);
  assign belowGrant   = NUM_SLOTS'((32'd1 << grant_slot) - 32'd1);

  assert_grant_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == prevValid);

  assert_refusal_slot_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_ok |-> grant_slot == '0);

  assert_first_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ok |-> (prevFreeView[grant_slot] && ((prevFreeView & belowGrant) == '0)));

  assert_refusal_correct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ok) |-> (prevFreeView == '0));

  assert_record_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ok |-> (slot_busy[grant_slot] &&
                  slot_config[grant_slot*EVENT_W +: EVENT_W] == prevId));

  assert_refusal_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ok && !prevClear) |->
      (slot_busy == prevBusy && slot_config == prevCfg));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prevClear |-> $onehot0(slot_busy));

  assert_free_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) + $countones(slot_busy) == NUM_SLOTS);

  assert_one_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_busy & ~prevBusy));

endmodule

bind pmu_slot_allocator pmu_slot_allocator_chk #(
  .NUM_SLOTS(NUM_SLOTS), .EVENT_W(EVENT_W)
) uChk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .req_valid(req_valid),
  .req_event_id(req_event_id), .req_mask(req_mask),
  .grant_valid(grant_valid), .grant_ok(grant_ok), .grant_slot(grant_slot),
  .slot_busy(slot_busy), .slot_config(slot_config), .free_count(free_count)
);

// File: tb/tb_pmu_slot_allocator.sv
`timescale 1ns/1ps
module tb_pmu_slot_allocator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_event_id = '0;
  logic [9:0]  req_mask = '0;
  logic        grant_valid;
  logic        grant_ok;
  logic [3:0]  grant_slot;
  logic [9:0]  slot_busy;
  logic [79:0] slot_config;
  logic [3:0]  free_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  pmu_slot_allocator dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .req_valid(req_valid),
    .req_event_id(req_event_id), .req_mask(req_mask),
    .grant_valid(grant_valid), .grant_ok(grant_ok), .grant_slot(grant_slot),
    .slot_busy(slot_busy), .slot_config(slot_config), .free_count(free_count)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgOf(input int s);
    return slot_config[s*8 +: 8];
  endfunction

  // Drive one request; outputs sampled at the following negedge
  task automatic issue(input logic [9:0] m, input logic [7:0] id, input logic withClear);
    @(negedge clk);
    req_valid = 1'b1; req_mask = m; req_event_id = id; clear = withClear;
    @(negedge clk);
    req_valid = 1'b0; req_mask = '0; req_event_id = '0; clear = 1'b0;
  endtask

  task automatic expectGrant(input string tag, input logic ok, input logic [3:0] slot);
    chk({tag, " grant_valid"}, 80'(grant_valid), 80'(1'b1));
    chk({tag, " grant_ok"}, 80'(grant_ok), 80'(ok));
    chk({tag, " grant_slot"}, 80'(grant_slot), 80'(slot));
  endtask

  task automatic doClear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk("R1 clear busy", 80'(slot_busy), 80'(0));
    chk("R1 clear free", 80'(free_count), 80'(10));
    chk("R1 clear config", slot_config, 80'(0));
  endtask

  task automatic testReset();
    chk("R1 reset busy", 80'(slot_busy), 80'(0));
    chk("R1 reset free", 80'(free_count), 80'(10));
    chk("R1 reset config", slot_config, 80'(0));
    chk("R2 idle grant_valid", 80'(grant_valid), 80'(0));
  endtask

  task automatic testFixed();
    issue(10'h3FC, 8'hA0, 1'b0);
    expectGrant("R3 wide first", 1'b1, 4'd2);
    issue(10'h001, 8'h11, 1'b0);
    expectGrant("R6 cycles", 1'b1, 4'd0);
    issue(10'h002, 8'h22, 1'b0);
    expectGrant("R6 instr", 1'b1, 4'd1);
    chk("R4 cfg slot0", 80'(cfgOf(0)), 80'(8'h11));
    chk("R4 cfg slot1", 80'(cfgOf(1)), 80'(8'h22));
    chk("R4 cfg slot2", 80'(cfgOf(2)), 80'(8'hA0));
    chk("R4 busy", 80'(slot_busy), 80'(10'h007));
    chk("R10 free", 80'(free_count), 80'(7));
    @(negedge clk);
    chk("R2 no request", 80'(grant_valid), 80'(0));
    doClear();
  endtask

  task automatic testWideThenNarrow();
    for (int i = 0; i < 6; i++) begin
      issue(10'h3FC, 8'h30 + 8'(i), 1'b0);
      expectGrant("R7 wide", 1'b1, 4'(2 + i));
    end
    issue(10'h080, 8'h77, 1'b0);
    expectGrant("R7 narrow blocked", 1'b0, 4'd0);
    chk("R5 busy kept", 80'(slot_busy), 80'(10'h0FC));
    chk("R5 cfg slot7 kept", 80'(cfgOf(7)), 80'(8'h35));
    chk("R10 free", 80'(free_count), 80'(4));
    doClear();
  endtask

  task automatic testNarrowThenWide();
    logic [3:0] expSlot [6] = '{4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8};
    issue(10'h080, 8'h77, 1'b0);
    expectGrant("R7 narrow first", 1'b1, 4'd7);
    for (int i = 0; i < 6; i++) begin
      issue(10'h3FC, 8'h40 + 8'(i), 1'b0);
      expectGrant("R7 wide after", 1'b1, expSlot[i]);
    end
    chk("R4 cfg slot8", 80'(cfgOf(8)), 80'(8'h45));
    chk("R10 free", 80'(free_count), 80'(3));
    doClear();
  endtask

  task automatic testPairConflict();
    issue(10'h080, 8'h51, 1'b0);
    expectGrant("R8 first", 1'b1, 4'd7);
    issue(10'h080, 8'h99, 1'b0);
    expectGrant("R8 second", 1'b0, 4'd0);
    chk("R8 cfg kept", 80'(cfgOf(7)), 80'(8'h51));
    issue(10'h000, 8'h5A, 1'b0);
    expectGrant("R5 zero mask", 1'b0, 4'd0);
    chk("R5 zero mask busy", 80'(slot_busy), 80'(10'h080));
    chk("R5 zero mask cfg0", 80'(cfgOf(0)), 80'(0));
    doClear();
  endtask

  task automatic testSparse();
    issue(10'h220, 8'h61, 1'b0);
    expectGrant("R3 sparse a", 1'b1, 4'd5);
    issue(10'h220, 8'h62, 1'b0);
    expectGrant("R3 sparse b", 1'b1, 4'd9);
    issue(10'h220, 8'h63, 1'b0);
    expectGrant("R5 sparse full", 1'b0, 4'd0);
    chk("R4 cfg slot9", 80'(cfgOf(9)), 80'(8'h62));
  endtask

  task automatic testClearWithRequest();
    // slots 5 and 9 held from the previous scenario
    issue(10'h3FC, 8'hC3, 1'b1);
    expectGrant("R9 clear+req", 1'b1, 4'd2);
    chk("R9 busy", 80'(slot_busy), 80'(10'h004));
    chk("R9 cfg slot9", 80'(cfgOf(9)), 80'(0));
    chk("R10 free", 80'(free_count), 80'(9));
  endtask

  task automatic testFill();
    doClear();
    issue(10'h001, 8'h01, 1'b0);
    issue(10'h002, 8'h02, 1'b0);
    for (int i = 0; i < 8; i++) begin
      issue(10'h3FC, 8'h10 + 8'(i), 1'b0);
      expectGrant("R3 fill", 1'b1, 4'(2 + i));
    end
    chk("R10 free zero", 80'(free_count), 80'(0));
    issue(10'h3FF, 8'hEE, 1'b0);
    expectGrant("R5 bank full", 1'b0, 4'd0);
    chk("R5 full busy", 80'(slot_busy), 80'(10'h3FF));
    doClear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFixed();
    testWideThenNarrow();
    testNarrowThenWide();
    testPairConflict();
    testSparse();
    testClearWithRequest();
    testFill();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule